// File: doc/BRIEF.md
# Iterative Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision floating-point words, each made of a sign bit, an 8-bit exponent stored with a bias of 127, and a 23-bit fraction whose leading one is implied. A one-cycle `start` pulse captures both operands and the operation select. The unit then steps through four phases, one after the other. The first phase tests for zero operands. The second aligns the significands. The third combines them. The fourth normalizes the result. The aligning and normalizing shifters move one bit per clock instead of using a wide barrel shifter, so the latency of an operation depends on its data.

Internally each significand has its hidden one restored and one extra guard bit below the fraction. Discarded bits are truncated. Inputs that are infinite, not-a-number or denormal are not handled. A completed operation raises `done` for one cycle. At the same time the result word and the two exponent range flags are updated, and they hold those values until the next operation completes.

Top module: `fp_addsub_iter`

## Requirements
- R1: After reset, `done`, `ovf`, `unf` and `result` are all zero.
- R2: When `op_sub` is 1, the unit inverts bit 31 (the sign) of `b_in` and then performs an addition with that changed operand.
- R3: An operand whose bits 30:0 are all zero counts as zero. If operand A is zero, the sign-adjusted B is returned unchanged. Otherwise, if B is zero, A is returned unchanged. Either way `done` comes 1 cycle after the start edge and both flags are 0.
- R4: Only the operand with the smaller exponent is shifted. It moves right one bit per cycle, and its exponent goes up by one each step, until the two exponents match. With an exponent gap d, a result that needs no normalizing shift arrives d+4 cycles after the start edge.
- R5: If the shifted significand reaches zero, which happens when the gap d is 25 or more, the operand with the larger exponent is returned unchanged 26 cycles after the start edge, with both flags 0.
- R6: When the signs differ, the smaller aligned significand is subtracted from the larger, and the result takes the sign of the larger. Equal magnitudes give the all-zero word 3+d cycles after the start edge.
- R7: When same-sign significands carry out of the top bit, the sum is shifted right once (truncating) and the exponent goes up by one.
- R8: If that increment would make the exponent field 255, `ovf` is set and the result is the sign followed by exponent field 255 and a zero fraction, 3+d cycles after the start edge. `unf` is 0.
- R9: Normalization shifts the significand left one bit per cycle and lowers the exponent by one each step, until the leading bit is one. With m shifts the result arrives d+4+m cycles after the start edge, and its fraction is the truncated stored bits.
- R10: If a normalization step would take the exponent field below 1, `unf` is set and the result is the all-zero word. `ovf` is 0.
- R11: A `start` pulse that arrives while an operation is in progress is ignored: that operation completes with its own operands and produces a single `done`.
- R12: `done` is high for exactly one cycle per operation. `result`, `ovf` and `unf` change only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_sub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| a_in | input | 32 | First operand: sign, biased exponent, fraction |
| b_in | input | 32 | Second operand, same layout as `a_in` |
| done | output | 1 | One-cycle pulse when a result is ready |
| result | output | 32 | Result word, held until the next completion |
| ovf | output | 1 | Exponent overflow flag for the last result |
| unf | output | 1 | Exponent underflow flag for the last result |

## Verification
The latency of each result follows from the operands. It is 1 cycle after the start edge for a zero operand and 26 for an alignment that shifts the significand out to zero. A cancellation or an overflow takes 3+d cycles, a normal result takes 4+d+m, and an underflow takes 4+d plus the normalizing shifts completed before it. The bench model computes this count together with the expected word. The bench counts rising edges from the start edge, samples `done` on falling edges, and checks that the pulse appears on exactly the predicted edge. Only then does it compare the result and both flags, and it also watches that no extra pulse follows.

// File: rtl/fpas_pkg.sv
`timescale 1ns/1ps
package fpas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZCHK,
    ST_ALIGN,
    ST_ADD,
    ST_NORM
  } fpas_state_e;

  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;
  localparam int DEF_GUARD  = 1;
endpackage

// File: rtl/fpas_unpack.sv
`timescale 1ns/1ps
module fpas_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GUARD  = 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1 + GUARD
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic              zero_o
);
  // Restore the implied leading one and append guard zeros.
  function automatic logic [SIG_W-1:0] widen(input logic [FRAC_W-1:0] f);
    return {1'b1, f, {GUARD{1'b0}}};
  endfunction

  assign sign_o = word_i[WORD_W-1];
  assign exp_o  = word_i[WORD_W-2 -: EXP_W];
  assign sig_o  = widen(word_i[FRAC_W-1:0]);
  assign zero_o = (word_i[WORD_W-2:0] == '0);
endmodule

// File: rtl/fpas_align_step.sv
`timescale 1ns/1ps
module fpas_align_step #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 25
) (
  input  logic [EXP_W-1:0] ea_i,
  input  logic [EXP_W-1:0] eb_i,
  input  logic [SIG_W-1:0] ma_i,
  input  logic [SIG_W-1:0] mb_i,
  output logic             equal_o,
  output logic             a_small_o,
  output logic [SIG_W-1:0] shifted_o,
  output logic [EXP_W-1:0] gap_o
);
  assign equal_o   = (ea_i == eb_i);
  assign a_small_o = (ea_i < eb_i);
  // One-position right shift of whichever significand has the lower exponent.
  assign shifted_o = a_small_o ? (ma_i >> 1) : (mb_i >> 1);
  assign gap_o     = a_small_o ? (eb_i - ea_i) : (ea_i - eb_i);
endmodule

// File: rtl/fpas_combine.sv
`timescale 1ns/1ps
module fpas_combine #(
  parameter int SIG_W = 25
) (
  input  logic             sa_i,
  input  logic             sb_i,
  input  logic [SIG_W-1:0] ma_i,
  input  logic [SIG_W-1:0] mb_i,
  output logic [SIG_W:0]   sum_o,
  output logic             sign_o
);
  function automatic logic [SIG_W:0] mag(input logic same, input logic [SIG_W-1:0] x,
                                         input logic [SIG_W-1:0] y);
    if (same)      return {1'b0, x} + {1'b0, y};
    else if (x >= y) return {1'b0, x} - {1'b0, y};
    else           return {1'b0, y} - {1'b0, x};
  endfunction

  assign sum_o  = mag(sa_i == sb_i, ma_i, mb_i);
  assign sign_o = (sa_i == sb_i) ? sa_i : ((ma_i >= mb_i) ? sa_i : sb_i);
endmodule

// File: rtl/fp_addsub_iter.sv
`timescale 1ns/1ps
module fp_addsub_iter #(
  parameter int EXP_W  = fpas_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpas_pkg::DEF_FRAC_W,
  parameter int GUARD  = fpas_pkg::DEF_GUARD,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1 + GUARD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] b_in,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              ovf,
  output logic              unf
);
  import fpas_pkg::*;

  localparam logic [EXP_W-1:0] EXP_TOP = '1;
  localparam logic [EXP_W-1:0] EXP_MIN = EXP_W'(1);

  fpas_state_e       state_q;
  logic [WORD_W-1:0] a_q, b_q, result_q;
  logic              sa_q, sb_q, rs_q;
  logic [EXP_W-1:0]  ea_q, eb_q, re_q;
  logic [SIG_W-1:0]  ma_q, mb_q, rm_q;
  logic              done_q, ovf_q, unf_q;

  logic             ua_s, ub_s, ua_z, ub_z;
  logic [EXP_W-1:0] ua_e, ub_e;
  logic [SIG_W-1:0] ua_m, ub_m;

  fpas_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD(GUARD)) u_unp_a (
    .word_i(a_q), .sign_o(ua_s), .exp_o(ua_e), .sig_o(ua_m), .zero_o(ua_z));
  fpas_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD(GUARD)) u_unp_b (
    .word_i(b_q), .sign_o(ub_s), .exp_o(ub_e), .sig_o(ub_m), .zero_o(ub_z));

  logic             al_equal, al_a_small;
  logic [SIG_W-1:0] al_shifted;
  logic [EXP_W-1:0] exp_gap;

  fpas_align_step #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_align (
    .ea_i(ea_q), .eb_i(eb_q), .ma_i(ma_q), .mb_i(mb_q),
    .equal_o(al_equal), .a_small_o(al_a_small), .shifted_o(al_shifted), .gap_o(exp_gap));

  logic [SIG_W:0] cb_sum;
  logic           cb_sign;

  fpas_combine #(.SIG_W(SIG_W)) u_comb (
    .sa_i(sa_q), .sb_i(sb_q), .ma_i(ma_q), .mb_i(mb_q), .sum_o(cb_sum), .sign_o(cb_sign));

  function automatic logic [WORD_W-1:0] pack(input logic s, input logic [EXP_W-1:0] e,
                                             input logic [SIG_W-1:0] m);
    return {s, e, m[SIG_W-2:GUARD]};
  endfunction

  // Named internal events, used by the checker.
  logic align_shift_ev, align_zero_ev, cancel_ev, carry_ev, ovf_ev, norm_shift_ev, unf_ev;
  assign align_shift_ev = (state_q == ST_ALIGN) && !al_equal && (al_shifted != '0);
  assign align_zero_ev  = (state_q == ST_ALIGN) && !al_equal && (al_shifted == '0);
  assign cancel_ev      = (state_q == ST_ADD) && (cb_sum == '0);
  assign carry_ev       = (state_q == ST_ADD) && cb_sum[SIG_W];
  assign ovf_ev         = carry_ev && (ea_q == EXP_TOP - EXP_MIN);
  assign norm_shift_ev  = (state_q == ST_NORM) && !rm_q[SIG_W-1] && (re_q != EXP_MIN);
  assign unf_ev         = (state_q == ST_NORM) && !rm_q[SIG_W-1] && (re_q == EXP_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q <= '0; b_q <= '0; result_q <= '0;
      sa_q <= 1'b0; sb_q <= 1'b0; rs_q <= 1'b0;
      ea_q <= '0; eb_q <= '0; re_q <= '0;
      ma_q <= '0; mb_q <= '0; rm_q <= '0;
      done_q <= 1'b0; ovf_q <= 1'b0; unf_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            a_q     <= a_in;
            b_q     <= {b_in[WORD_W-1] ^ op_sub, b_in[WORD_W-2:0]};
            state_q <= ST_ZCHK;
          end
        end
        ST_ZCHK: begin
          if (ua_z || ub_z) begin
            result_q <= ua_z ? b_q : a_q;
            ovf_q <= 1'b0; unf_q <= 1'b0; done_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            sa_q <= ua_s; ea_q <= ua_e; ma_q <= ua_m;
            sb_q <= ub_s; eb_q <= ub_e; mb_q <= ub_m;
            state_q <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (al_equal) begin
            state_q <= ST_ADD;
          end else if (align_zero_ev) begin
            result_q <= al_a_small ? b_q : a_q;
            ovf_q <= 1'b0; unf_q <= 1'b0; done_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (al_a_small) begin
            ma_q <= al_shifted; ea_q <= ea_q + EXP_MIN;
          end else begin
            mb_q <= al_shifted; eb_q <= eb_q + EXP_MIN;
          end
        end
        ST_ADD: begin
          rs_q <= cb_sign;
          if (cancel_ev) begin
            result_q <= '0; ovf_q <= 1'b0; unf_q <= 1'b0; done_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (ovf_ev) begin
            result_q <= {cb_sign, EXP_TOP, {FRAC_W{1'b0}}};
            ovf_q <= 1'b1; unf_q <= 1'b0; done_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            if (carry_ev) begin
              rm_q <= cb_sum[SIG_W:1];
              re_q <= ea_q + EXP_MIN;
            end else begin
              rm_q <= cb_sum[SIG_W-1:0];
              re_q <= ea_q;
            end
            state_q <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (rm_q[SIG_W-1]) begin
            result_q <= pack(rs_q, re_q, rm_q);
            ovf_q <= 1'b0; unf_q <= 1'b0; done_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (unf_ev) begin
            result_q <= '0; ovf_q <= 1'b0; unf_q <= 1'b1; done_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rm_q <= rm_q << 1;
            re_q <= re_q - EXP_MIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign result = result_q;
  assign ovf    = ovf_q;
  assign unf    = unf_q;
endmodule

// File: rtl/fpas_chk.sv
`timescale 1ns/1ps
module fpas_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              ovf,
  input logic              unf,
  input logic [WORD_W-1:0] result,
  input logic              align_shift_ev,
  input logic              align_zero_ev,
  input logic [EXP_W-1:0]  exp_gap
);
  // R12: one-cycle completion pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R12: outputs move only on completion
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(ovf) && $stable(unf)));

  // R8: overflow result encoding
  p_ovf_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (result[WORD_W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] == '0 && !unf));

  // R10: underflow gives zero word
  p_unf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf) |-> (result == '0 && !ovf));

  // R4: each alignment step closes the exponent gap by exactly one
  p_gap_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    align_shift_ev |=> (exp_gap == $past(exp_gap) - EXP_W'(1)));

  // R5: a shift-out to zero finishes the operation on the next cycle
  p_early_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    align_zero_ev |=> (done && !ovf && !unf));
endmodule

bind fp_addsub_iter fpas_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ovf(ovf), .unf(unf), .result(result),
  .align_shift_ev(align_shift_ev), .align_zero_ev(align_zero_ev), .exp_gap(exp_gap));

// File: tb/fp_addsub_iter_tb_top.sv
`timescale 1ns/1ps
module fp_addsub_iter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_sub = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic done, ovf, unf;
  logic [31:0] result;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  fp_addsub_iter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_in(a_in), .b_in(b_in), .done(done), .result(result), .ovf(ovf), .unf(unf));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      checks++;
      $display("FAIL R12 watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] m_res;
  logic        m_ovf, m_unf;
  int          m_lat;
  string       m_tag;

  // Reference computed from the requirements with plain integers.
  task automatic model(input logic [31:0] a, input logic [31:0] b0, input logic sub);
    logic [31:0] b;
    int ea, eb, e, d, ma, mb, s, m;
    logic sa, sb, sg, carried;
    b = {b0[31] ^ sub, b0[30:0]};
    m_ovf = 1'b0; m_unf = 1'b0; carried = 1'b0;
    if (a[30:0] == 0) begin m_res = b; m_lat = 1; m_tag = "R3"; return; end
    if (b[30:0] == 0) begin m_res = a; m_lat = 1; m_tag = "R3"; return; end
    sa = a[31]; ea = int'(a[30:23]); ma = (int'(a[22:0]) + (1 << 23)) * 2;
    sb = b[31]; eb = int'(b[30:23]); mb = (int'(b[22:0]) + (1 << 23)) * 2;
    if (ea < eb) begin
      d = eb - ea;
      if (d >= 25) begin m_res = b; m_lat = 26; m_tag = "R5"; return; end
      ma = ma >> d; e = eb;
    end else begin
      d = ea - eb;
      if (d >= 25) begin m_res = a; m_lat = 26; m_tag = "R5"; return; end
      mb = mb >> d; e = ea;
    end
    if (sa == sb) begin
      s = ma + mb; sg = sa;
      if (s >= (1 << 25)) begin
        s = s >> 1; e = e + 1; carried = 1'b1;
        if (e == 255) begin
          m_ovf = 1'b1; m_res = {sg, 8'hFF, 23'h0}; m_lat = d + 3; m_tag = "R8"; return;
        end
      end
    end else begin
      if (ma == mb) begin m_res = '0; m_lat = d + 3; m_tag = "R6"; return; end
      if (ma > mb) begin s = ma - mb; sg = sa; end
      else begin s = mb - ma; sg = sb; end
    end
    m = 0;
    while (s < (1 << 24)) begin
      if (e == 1) begin m_unf = 1'b1; m_res = '0; m_lat = d + 4 + m; m_tag = "R10"; return; end
      s = s << 1; e = e - 1; m++;
    end
    m_res = {sg, e[7:0], s[23:1]};
    m_lat = d + 4 + m;
    if (m > 0) m_tag = "R9";
    else if (carried) m_tag = "R7";
    else if (sa != sb) m_tag = "R6";
    else m_tag = "R4";
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                        input string tag_over, input bit inject);
    int cnt;
    int ndone;
    string tg;
    model(a, b, sub);
    tg = (tag_over.len() != 0) ? tag_over : m_tag;
    @(negedge clk);
    a_in = a; b_in = b; op_sub = sub; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0; ndone = 0;
    while (ndone == 0 && cnt < 200) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (inject && cnt == 1) begin
        a_in = 32'h4120_0000; b_in = 32'hC2C8_0000; op_sub = 1'b1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) ndone = 1;
    end
    chk(tg, cnt, m_lat, "latency");
    chk(tg, result, m_res, "result");
    chk(tg, {31'h0, ovf}, {31'h0, m_ovf}, "ovf");
    chk(tg, {31'h0, unf}, {31'h0, m_unf}, "unf");
  endtask

  task automatic quiet_check(input int n, input string tag);
    logic [31:0] held;
    int extra;
    held = result; extra = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(tag, extra, 0, "extra done pulses");
    chk(tag, result, held, "held result");
  endtask

  initial begin
    logic [31:0] ra, rb;
    int ea, eb, off;
    void'($urandom(32'd13579));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {29'h0, done, ovf, unf}, 32'h0, "flags in reset");
    chk("R1", result, 32'h0, "result in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {29'h0, done, ovf, unf}, 32'h0, "flags after reset");

    run_op(32'h3F80_0000, 32'h3F80_0000, 1'b0, "R7", 1'b0);   // 1+1 = 2
    chk("R7", result, 32'h4000_0000, "1+1 word");
    run_op(32'h4040_0000, 32'h3F80_0000, 1'b1, "R2", 1'b0);   // 3-1 = 2
    chk("R2", result, 32'h4000_0000, "3-1 word");
    run_op(32'h3F80_0000, 32'h3F80_0000, 1'b1, "R6", 1'b0);   // 1-1 = +0
    run_op(32'h0000_0000, 32'h3F80_0000, 1'b1, "R3", 1'b0);   // 0-1
    chk("R3", result, 32'hBF80_0000, "0-1 word");
    run_op(32'hC0A0_0000, 32'h8000_0000, 1'b0, "R3", 1'b0);   // -5 + -0
    run_op(32'h3F80_0000, 32'h3080_0000, 1'b0, "R5", 1'b0);   // gap 30
    chk("R5", result, 32'h3F80_0000, "early exit word");
    run_op(32'h7F00_0000, 32'h7F00_0000, 1'b0, "R8", 1'b0);   // overflow
    run_op(32'h0080_0000, 32'h0080_0001, 1'b1, "R10", 1'b0);  // underflow
    run_op(32'h3FC0_0000, 32'h3F80_0001, 1'b1, "R9", 1'b0);   // 1.5-1.0000001
    run_op(32'h4120_0000, 32'h3F00_0000, 1'b0, "R4", 1'b0);   // 10 + 0.5
    run_op(32'h3F80_0000, 32'h3F80_0000, 1'b0, "R11", 1'b1);  // start injected mid-op
    chk("R11", result, 32'h4000_0000, "injected start ignored");
    quiet_check(10, "R11");
    quiet_check(6, "R12");

    for (int k = 0; k < 600; k++) begin
      ea = 1 + int'($urandom % 254);
      if (k % 8 == 0) ea = 254 - int'($urandom % 3);
      if (k % 8 == 1) ea = 1 + int'($urandom % 3);
      off = int'($urandom % 61) - 30;
      eb = ea + off;
      if (eb < 1) eb = 1;
      if (eb > 254) eb = 254;
      ra = {1'($urandom), ea[7:0], 23'($urandom)};
      rb = {1'($urandom), eb[7:0], 23'($urandom)};
      if (k % 5 == 2) rb[22:0] = ra[22:0];
      if (k % 17 == 3) ra[30:0] = '0;
      if (k % 19 == 4) rb[30:0] = '0;
      run_op(ra, rb, 1'($urandom), "", 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule